// File: doc/BRIEF.md
# Translation Cache with Selective Flush

This block is a small, fully associative cache of address translations. Each entry maps a logical page number to a physical page number and carries a write-protect bit and a global bit. A lookup is purely combinational: the hit flag, the physical page and the attributes for the presented logical page appear in the same cycle. New translations come in through a fill port, typically after a table walk elsewhere in the memory system. A fill whose page is already cached replaces that entry. Otherwise the fill goes to the lowest-numbered free entry, or to a round-robin victim when every entry is valid.

A flush port removes translations in one clock cycle. It has four kinds. Flush-all clears every entry. Flush-by-address clears the entry for one page whatever its global bit. The two non-global kinds, by address or across the whole cache, clear only entries whose global bit is clear. This lets shared mappings survive a context switch.

The allocator is written as a small chooser with three named outcomes. PICK_HIT rewrites a matching entry. PICK_FREE takes the lowest free entry. PICK_VICTIM takes the entry under the round-robin pointer and advances the pointer by one, wrapping from the last entry to entry 0. The pointer is the only state that carries from one fill decision to the next.

Top module: `tcache_top`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses.
- R2: A lookup reports in the same cycle a hit with the cached physical page, write-protect and global bits. On a miss, `lk_hit`, `lk_ppn`, `lk_wp` and `lk_glob` are all 0.
- R3: A fill for a page not yet cached writes the lowest-numbered invalid entry. When all 16 entries are valid, it writes the entry under a round-robin pointer. The pointer starts at entry 0 after reset and advances by one (wrapping) only on such a replacement.
- R4: A fill for a page already cached overwrites that entry in place. It neither consumes a free entry nor moves the round-robin pointer.
- R5: Flush kind 0 (`fl_kind`=2'd0) invalidates every entry, global or not.
- R6: Flush kind 1 invalidates the entry whose logical page equals `fl_lpn`, whatever its global bit.
- R7: Flush kind 2 invalidates the entry whose logical page equals `fl_lpn` only if its global bit is clear.
- R8: Flush kind 3 invalidates every entry whose global bit is clear and keeps all global entries.
- R9: Each flush takes effect at the next clock edge. A lookup in the same cycle as a flush sees the entry as it was before the flush.
- R10: When a fill and a flush occur in the same cycle, the fill's slot is chosen from the contents before the flush, and the filled translation is valid afterwards even if the flush would have removed it.
- R11: Without a fill or flush, cached contents do not change, so a repeated lookup of the same page returns the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_lpn | input | 20 | Logical page number to look up |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 20 | Physical page on hit, else 0 |
| lk_wp | output | 1 | Write-protect bit on hit, else 0 |
| lk_glob | output | 1 | Global bit on hit, else 0 |
| fl_valid | input | 1 | Flush request this cycle |
| fl_kind | input | 2 | 0 all, 1 by address, 2 non-global by address, 3 all non-global |
| fl_lpn | input | 20 | Logical page for address flushes |
| fi_valid | input | 1 | Fill request this cycle |
| fi_lpn | input | 20 | Logical page of the new translation |
| fi_ppn | input | 20 | Physical page of the new translation |
| fi_wp | input | 1 | Write-protect bit of the new translation |
| fi_glob | input | 1 | Global bit of the new translation |

## Verification
The bench fills all 16 entries and then adds further new pages. A wrong round-robin start or advance would evict a different page than the reference model, and the first-filled page would still hit. It refills an existing page and then fills the cache to capacity. A design that duplicated the entry instead of overwriting it would evict early. It flushes global and non-global entries with each of the four kinds, so a design that ignored or inverted the global test would keep or lose the wrong pages. It also looks up an entry in the same cycle as its flush, and fills during a flush-all. An early invalidation would show a miss too soon, and a flush that overrode the fill would leave the new page missing.

// File: rtl/tcache_pkg.sv
package tcache_pkg;
    typedef enum logic [1:0] {
        FL_ALL     = 2'd0,
        FL_ADDR    = 2'd1,
        FL_NG_ADDR = 2'd2,
        FL_NG_ALL  = 2'd3
    } flush_kind_e;

    typedef enum logic [1:0] {
        PICK_HIT    = 2'd0,
        PICK_FREE   = 2'd1,
        PICK_VICTIM = 2'd2
    } pick_e;
endpackage

// File: rtl/tcache_entry.sv
module tcache_entry
    import tcache_pkg::*;
#(
    parameter int LPN_W = 20,
    parameter int PPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LPN_W-1:0] wr_lpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             wr_wp,
    input  logic             wr_glob,
    input  logic             fl_valid,
    input  logic [1:0]       fl_kind,
    input  logic [LPN_W-1:0] fl_lpn,
    input  logic [LPN_W-1:0] lk_lpn,
    output logic             valid_o,
    output logic             glob_o,
    output logic [PPN_W-1:0] ppn_o,
    output logic             wp_o,
    output logic             lk_match_o,
    output logic             fi_match_o
);
    logic             valid_q;
    logic             glob_q;
    logic             wp_q;
    logic [LPN_W-1:0] lpn_q;
    logic [PPN_W-1:0] ppn_q;
    logic             kill;
    logic             addr_eq;
    flush_kind_e      kind;

    assign kind    = flush_kind_e'(fl_kind);
    assign addr_eq = (lpn_q == fl_lpn);

    always_comb begin
        kill = 1'b0;
        if (fl_valid && valid_q) begin
            unique case (kind)
                FL_ALL:     kill = 1'b1;
                FL_ADDR:    kill = addr_eq;
                FL_NG_ADDR: kill = addr_eq && !glob_q;
                FL_NG_ALL:  kill = !glob_q;
                default:    kill = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            glob_q  <= 1'b0;
            wp_q    <= 1'b0;
            lpn_q   <= '0;
            ppn_q   <= '0;
        end else if (wr_en) begin
            valid_q <= 1'b1;
            glob_q  <= wr_glob;
            wp_q    <= wr_wp;
            lpn_q   <= wr_lpn;
            ppn_q   <= wr_ppn;
        end else if (kill) begin
            valid_q <= 1'b0;
        end
    end

    assign valid_o    = valid_q;
    assign glob_o     = glob_q;
    assign ppn_o      = ppn_q;
    assign wp_o       = wp_q;
    assign lk_match_o = valid_q && (lpn_q == lk_lpn);
    assign fi_match_o = valid_q && (lpn_q == wr_lpn);
endmodule

// File: rtl/tcache_alloc.sv
module tcache_alloc
    import tcache_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fi_valid,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] match_vec,
    output logic [IDX_W-1:0]   slot_o
);
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] free_idx;
    logic             any_hit;
    logic             any_free;
    pick_e            pick;

    always_comb begin
        any_hit = 1'b0;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                any_hit = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (any_hit)       pick = PICK_HIT;
        else if (any_free) pick = PICK_FREE;
        else               pick = PICK_VICTIM;
    end

    always_comb begin
        unique case (pick)
            PICK_HIT:    slot_o = hit_idx;
            PICK_FREE:   slot_o = free_idx;
            PICK_VICTIM: slot_o = ptr_q;
            default:     slot_o = ptr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (fi_valid && pick == PICK_VICTIM) begin
            ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/tcache_top.sv
module tcache_top
    import tcache_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int LPN_W   = 20,
    parameter int PPN_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LPN_W-1:0] lk_lpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_wp,
    output logic             lk_glob,
    input  logic             fl_valid,
    input  logic [1:0]       fl_kind,
    input  logic [LPN_W-1:0] fl_lpn,
    input  logic             fi_valid,
    input  logic [LPN_W-1:0] fi_lpn,
    input  logic [PPN_W-1:0] fi_ppn,
    input  logic             fi_wp,
    input  logic             fi_glob
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] glob_vec;
    logic [ENTRIES-1:0] wp_vec;
    logic [ENTRIES-1:0] lk_vec;
    logic [ENTRIES-1:0] fi_vec;
    logic [PPN_W-1:0]   ppn_arr [ENTRIES];
    logic [IDX_W-1:0]   slot;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        tcache_entry #(.LPN_W(LPN_W), .PPN_W(PPN_W)) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (fi_valid && (slot == IDX_W'(g))),
            .wr_lpn     (fi_lpn),
            .wr_ppn     (fi_ppn),
            .wr_wp      (fi_wp),
            .wr_glob    (fi_glob),
            .fl_valid   (fl_valid),
            .fl_kind    (fl_kind),
            .fl_lpn     (fl_lpn),
            .lk_lpn     (lk_lpn),
            .valid_o    (valid_vec[g]),
            .glob_o     (glob_vec[g]),
            .ppn_o      (ppn_arr[g]),
            .wp_o       (wp_vec[g]),
            .lk_match_o (lk_vec[g]),
            .fi_match_o (fi_vec[g])
        );
    end

    tcache_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .clk       (clk),
        .rst_n     (rst_n),
        .fi_valid  (fi_valid),
        .valid_vec (valid_vec),
        .match_vec (fi_vec),
        .slot_o    (slot)
    );

    always_comb begin
        lk_hit  = 1'b0;
        lk_ppn  = '0;
        lk_wp   = 1'b0;
        lk_glob = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lk_vec[i]) begin
                lk_hit  = 1'b1;
                lk_ppn  = ppn_arr[i];
                lk_wp   = wp_vec[i];
                lk_glob = glob_vec[i];
            end
        end
    end
endmodule

// File: rtl/tcache_chk.sv
module tcache_chk #(
    parameter int LPN_W = 20,
    parameter int PPN_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LPN_W-1:0] lk_lpn,
    input logic             lk_hit,
    input logic [PPN_W-1:0] lk_ppn,
    input logic             lk_glob,
    input logic             fl_valid,
    input logic [1:0]       fl_kind,
    input logic [LPN_W-1:0] fl_lpn,
    input logic             fi_valid,
    input logic [LPN_W-1:0] fi_lpn,
    input logic [PPN_W-1:0] fi_ppn
);
    // R2
    fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fi_valid |=> (lk_lpn != $past(fi_lpn)) || (lk_hit && lk_ppn == $past(fi_ppn)));

    // R5
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && fl_kind == 2'd0 && !fi_valid) |=> !lk_hit);

    // R6
    flush_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && fl_kind == 2'd1 && !(fi_valid && fi_lpn == fl_lpn))
        |=> (lk_lpn != $past(fl_lpn)) || !lk_hit);

    // R7
    flush_ng_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && fl_kind == 2'd2 && !fi_valid)
        |=> (lk_lpn != $past(fl_lpn)) || !lk_hit || lk_glob);

    // R8
    flush_ng_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && fl_kind == 2'd3 && !fi_valid) |=> !lk_hit || lk_glob);

    // R11
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_valid && !fi_valid)
        |=> !$stable(lk_lpn) || ($stable(lk_hit) && $stable(lk_ppn)));
endmodule

bind tcache_top tcache_chk #(.LPN_W(LPN_W), .PPN_W(PPN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_lpn   (lk_lpn),
    .lk_hit   (lk_hit),
    .lk_ppn   (lk_ppn),
    .lk_glob  (lk_glob),
    .fl_valid (fl_valid),
    .fl_kind  (fl_kind),
    .fl_lpn   (fl_lpn),
    .fi_valid (fi_valid),
    .fi_lpn   (fi_lpn),
    .fi_ppn   (fi_ppn)
);

// File: tb/tcache_top_bench.sv
module tcache_top_bench;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] lk_lpn = '0;
    logic        lk_hit;
    logic [19:0] lk_ppn;
    logic        lk_wp;
    logic        lk_glob;
    logic        fl_valid = 1'b0;
    logic [1:0]  fl_kind = '0;
    logic [19:0] fl_lpn = '0;
    logic        fi_valid = 1'b0;
    logic [19:0] fi_lpn = '0;
    logic [19:0] fi_ppn = '0;
    logic        fi_wp = 1'b0;
    logic        fi_glob = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // reference model state
    bit          m_v [N];
    bit          m_g [N];
    bit          m_w [N];
    int          m_l [N];
    int          m_p [N];
    int          m_ptr;

    always #2 clk = ~clk;

    tcache_top u_tcache_top (
        .clk(clk), .rst_n(rst_n), .lk_lpn(lk_lpn), .lk_hit(lk_hit),
        .lk_ppn(lk_ppn), .lk_wp(lk_wp), .lk_glob(lk_glob),
        .fl_valid(fl_valid), .fl_kind(fl_kind), .fl_lpn(fl_lpn),
        .fi_valid(fi_valid), .fi_lpn(fi_lpn), .fi_ppn(fi_ppn),
        .fi_wp(fi_wp), .fi_glob(fi_glob)
    );

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_g[i] = 0; m_w[i] = 0; m_l[i] = 0; m_p[i] = 0;
        end
        m_ptr = 0;
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        bit eh = 0; bit ew = 0; bit eg = 0; int ep = 0;
        for (int i = 0; i < N; i++) begin
            if (!eh && m_v[i] && m_l[i] == int'(lk_lpn)) begin
                eh = 1; ep = m_p[i]; ew = m_w[i]; eg = m_g[i];
            end
        end
        check(lk_hit == eh, tag, "hit", int'(lk_hit), int'(eh));
        check(int'(lk_ppn) == ep && lk_wp == ew && lk_glob == eg, tag, "ppn/wp/glob",
              int'({lk_ppn, lk_wp, lk_glob}), int'({ep[19:0], ew, eg}));
    endtask

    task automatic model_update();
        bit nv [N];
        int slot = -1;
        for (int i = 0; i < N; i++)
            if (slot < 0 && m_v[i] && m_l[i] == int'(fi_lpn)) slot = i;
        if (slot < 0)
            for (int i = 0; i < N; i++)
                if (slot < 0 && !m_v[i]) slot = i;
        if (slot < 0 && fi_valid) begin
            slot = m_ptr;
            m_ptr = (m_ptr + 1) % N;
        end
        for (int i = 0; i < N; i++) begin
            bit k = 0;
            if (fl_valid && m_v[i]) begin
                case (fl_kind)
                    2'd0: k = 1;
                    2'd1: k = (m_l[i] == int'(fl_lpn));
                    2'd2: k = (m_l[i] == int'(fl_lpn)) && !m_g[i];
                    default: k = !m_g[i];
                endcase
            end
            nv[i] = m_v[i] && !k;
        end
        for (int i = 0; i < N; i++) m_v[i] = nv[i];
        if (fi_valid) begin
            m_v[slot] = 1; m_l[slot] = int'(fi_lpn); m_p[slot] = int'(fi_ppn);
            m_w[slot] = fi_wp; m_g[slot] = fi_glob;
        end
    endtask

    // one clock: compare now, advance model at the edge, return at negedge idle
    task automatic cyc(input string tag);
        #1;
        compare(tag);
        @(posedge clk);
        #0;
        model_update();
        @(negedge clk);
        fl_valid = 0; fi_valid = 0;
    endtask

    task automatic fill(input int l, input int p, input bit w, input bit g, input string tag);
        fi_valid = 1; fi_lpn = l[19:0]; fi_ppn = p[19:0]; fi_wp = w; fi_glob = g;
        lk_lpn = l[19:0];
        cyc(tag);
    endtask

    task automatic flush(input int kind, input int l, input int look, input string tag);
        fl_valid = 1; fl_kind = kind[1:0]; fl_lpn = l[19:0]; lk_lpn = look[19:0];
        cyc(tag);
    endtask

    task automatic look(input int l, input string tag);
        lk_lpn = l[19:0];
        cyc(tag);
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: empty after reset
        look('h00000, "R1"); look('h00abc, "R1");

        // R2: fills and same-cycle lookups
        fill('h00111, 'h0a001, 1, 0, "R2");
        fill('h00222, 'h0b002, 0, 1, "R2");
        fill('h00333, 'h0c003, 0, 0, "R2");
        look('h00111, "R2"); look('h00222, "R2"); look('h00333, "R2");

        // R4: refill in place
        fill('h00111, 'h0d00d, 0, 0, "R4");
        look('h00111, "R4");
        for (int i = 0; i < 13; i++) fill('h01000 + i, 'h20000 + i, 0, 0, "R4");
        look('h00111, "R4"); look('h00333, "R4"); look('h0100c, "R4");

        // R3: cache full, round-robin victims start at entry 0
        fill('h05000, 'h35000, 0, 0, "R3");
        look('h00111, "R3"); look('h00222, "R3");
        fill('h05001, 'h35001, 0, 0, "R3");
        look('h00222, "R3"); look('h00333, "R3"); look('h05001, "R3");

        // R9: lookup sees pre-flush state, gone next cycle
        flush(1, 'h00333, 'h00333, "R9");
        look('h00333, "R9");

        // R7: non-global address flush spares global
        fill('h07777, 'h17777, 1, 1, "R7");
        flush(2, 'h07777, 'h07777, "R7");
        look('h07777, "R7");
        flush(2, 'h05000, 'h05000, "R7");
        look('h05000, "R7");

        // R6: address flush removes a global entry
        flush(1, 'h07777, 'h07777, "R6");
        look('h07777, "R6");

        // R8: all non-global flush keeps globals
        fill('h08880, 'h18880, 0, 1, "R8");
        fill('h08881, 'h18881, 1, 0, "R8");
        flush(3, 0, 'h08880, "R8");
        look('h08880, "R8"); look('h08881, "R8"); look('h01005, "R8");

        // R10: fill during flush-all survives
        fill('h09990, 'h19990, 0, 1, "R10");
        fl_valid = 1; fl_kind = 2'd0;
        fill('h09991, 'h19991, 1, 0, "R10");
        look('h09991, "R10"); look('h09990, "R10"); look('h08880, "R10");

        // R5: flush all
        fill('h0aaa0, 'h1aaa0, 0, 1, "R5");
        flush(0, 0, 'h0aaa0, "R5");
        look('h0aaa0, "R5"); look('h09991, "R5");

        // R11 and mixed traffic over a small page pool
        for (int n = 0; n < 600; n++) begin
            int r = $urandom_range(0, 9);
            lk_lpn = 20'($urandom_range(0, 23));
            if (r < 5) begin
                fi_valid = 1; fi_lpn = 20'($urandom_range(0, 23));
                fi_ppn = 20'($urandom); fi_wp = 1'($urandom); fi_glob = 1'($urandom);
            end
            if (r == 5 || r == 6 || (r == 4 && n % 7 == 0)) begin
                fl_valid = 1; fl_kind = 2'($urandom);
                fl_lpn = 20'($urandom_range(0, 23));
            end
            cyc("R11");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule